// File: doc/BRIEF.md
# Linked Context Frame Save/Restore Sequencer

This block moves a processor's upper register context between a parallel register port and memory. The memory holds 16-word context frames that are chained together. Unused frames form a free list, and each free frame's first word points at the next free frame. A call takes the head frame off that list and reads its link word. It then stores the current link word, the status word and fourteen registers into the frame. Finally it points the link word at the new frame and advances the free pointer. A return reads a frame back, hands the frame back to the free list by writing the old free pointer into the frame's first word, and reloads the link word from the frame.

A pointer is a 20-bit value: a 4-bit segment in bits 19:16 and a 16-bit offset in bits 15:0. The status word carries a 7-bit nesting field, and a prefix of leading ones sets the width of that field's count. A call raises the count and a return checks it. Faults are reported as flag outputs that are valid while `done` is high. Memory is reached one word at a time through a request/ready handshake.

Top module: `ctx_switch_engine`

## Requirements
- R1: Frame word k of pointer p is at address {p[19:16], 6'b0, p[15:0], 6'b0} + 4*k, so the segment lies in address bits 31:28 and the offset in bits 21:6.
- R2: A call first reads frame word 0, the next free pointer. It then writes all 16 frame words in rising address order: the incoming link word, the incoming status word, then `regs_in` words 0 to 13.
- R3: After a call, `link_out` holds the following fields: bits 31:24 = `prio_in`, bit 23 = `int_en_in`, bit 22 = 1, bits 21:20 from `link_in`, and bits 19:0 = the old free pointer. `free_out` bits 19:0 take the link word that was read, and bits 31:20 are kept. `regs_out` word 1 is `call_ra_in`, and every other word is passed through unchanged.
- R4: A call with `free_in[19:0]` equal to zero raises `trap_free_empty`. It makes no memory access and returns the link, status and free values unchanged.
- R5: A call whose `free_in` equals `limit_in` raises `trap_free_last` and still completes normally.
- R6: A return raises `trap_no_ctx` when `link_in[19:0]` is zero. It raises `trap_ctx_kind` when bit 22 of `link_in` (the upper-context flag) is clear. Either fault aborts the return with no memory access and with the free pointer unchanged.
- R7: A return reads frame words 0 to 15 of the frame at `link_in`, then writes `free_in` into word 0. The results are: `link_out` = word 0, `stat_out` = word 1, `regs_out` word k = frame word k+2, and `free_out` = {free_in[31:20], link_in[19:0]}.
- R8: Status bit 7 enables nesting. Bits 6:0 form the nesting field, and the value 7'h7F means that counting is off. With n leading ones, the low 7-n bits are the count. A call with counting on increments the field. Every call that completes sets status bit 7.
- R9: If the increment leaves a zero count (the count taken from the incremented value's own prefix), the call raises `trap_depth_over` and aborts with no memory access, and `stat_out` is unchanged.
- R10: A return with counting on and a zero count raises `trap_depth_under` and aborts with no memory access.
- R11: After a return, `ret_pc` equals word 1 of `regs_in` as sampled at the start, with bit 0 forced to zero.
- R12: At most one word moves per cycle with `mem_req` and `mem_ready` both high. A request's address, direction and data stay stable until it is accepted. `busy` is high from the cycle after the start until the last word completes, `done` pulses for one cycle after that, and a start request while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_call | input | 1 | Begin a call (wins over start_ret) |
| start_ret | input | 1 | Begin a return |
| link_in | input | 32 | Current previous-context link word |
| stat_in | input | 32 | Current status word |
| free_in | input | 32 | Current free-list head pointer |
| limit_in | input | 32 | Free-list limit pointer |
| prio_in | input | 8 | Current priority number |
| int_en_in | input | 1 | Current interrupt enable |
| call_ra_in | input | 32 | Return address placed into register word 1 by a call |
| regs_in | input | 448 | Fourteen register words, word k at bits 32k+31:32k |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse; results valid |
| link_out | output | 32 | New link word |
| stat_out | output | 32 | New status word |
| free_out | output | 32 | New free-list head pointer |
| regs_out | output | 448 | Register words after the operation |
| ret_pc | output | 32 | Return target with bit 0 cleared |
| trap_free_empty | output | 1 | Free list empty on call |
| trap_free_last | output | 1 | Call used the limit frame |
| trap_depth_over | output | 1 | Nesting count overflow on call |
| trap_depth_under | output | 1 | Nesting count underflow on return |
| trap_no_ctx | output | 1 | Return with a null link |
| trap_ctx_kind | output | 1 | Return with the upper-context flag clear |

## Verification
A wrong word index or a wrong base register shows up on the very next accepted memory handshake as a wrong address or wrong write data. A scoreboard that predicts every access in order therefore exposes it within one transfer. Corruption of the captured pointers, the link word that was read, or the nesting field stays hidden until `done`. It then appears as a wrong `free_out`, `link_out` or `stat_out`, and it breaks the next chained call or return, whose addresses come from those values. The abort paths are proved at the ports by the absence of any memory request between the start and `done`.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    localparam int WORD_W       = 32;
    localparam int PTR_W        = 20;
    localparam int LNK_UPPER    = 22;   // upper-context flag in the link word
    localparam int LNK_PIE      = 23;   // saved interrupt enable
    localparam int LNK_PRIO_LSB = 24;   // saved priority, bits 31:24

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_RD_LINK,
        S_WR_FRAME,
        S_RD_FRAME,
        S_WR_BACK,
        S_FINISH
    } phase_e;

    typedef enum logic {
        OP_CALL,
        OP_RET
    } op_e;

    typedef struct packed {
        logic free_empty;
        logic free_last;
        logic depth_over;
        logic depth_under;
        logic no_ctx;
        logic ctx_kind;
    } trap_t;

    // segment -> address bits 31:28, offset -> address bits 21:6
    function automatic logic [WORD_W-1:0] frame_base(input logic [PTR_W-1:0] p);
        return {p[19:16], 6'b0, p[15:0], 6'b0};
    endfunction

endpackage

// File: rtl/ctx_depth_unit.sv
module ctx_depth_unit #(
    parameter int DEPTH_W = 7
) (
    input  logic [DEPTH_W-1:0] field,
    input  logic               enable,
    output logic               counting,
    output logic [DEPTH_W-1:0] field_inc,
    output logic               inc_wraps,
    output logic               count_zero
);

    function automatic int lead_ones(input logic [DEPTH_W-1:0] f);
        int  n;
        logic run;
        n   = 0;
        run = 1'b1;
        for (int i = DEPTH_W - 1; i >= 0; i--) begin
            if (run && f[i]) n++;
            else             run = 1'b0;
        end
        return n;
    endfunction

    function automatic logic [DEPTH_W-1:0] count_of(input logic [DEPTH_W-1:0] f);
        logic [DEPTH_W-1:0] m;
        int n;
        n = lead_ones(f);
        for (int i = 0; i < DEPTH_W; i++) m[i] = (i < (DEPTH_W - n));
        return f & m;
    endfunction

    logic [DEPTH_W-1:0] bumped;

    always_comb begin
        counting   = enable && (field != '1);
        bumped     = field + 1'b1;
        inc_wraps  = counting && (count_of(bumped) == '0);
        field_inc  = inc_wraps ? field : bumped;
        count_zero = (count_of(field) == '0);
    end

endmodule

// File: rtl/ctx_step_ctr.sv
module ctx_step_ctr #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          adv,
    output logic [IW-1:0] idx,
    output logic          last
);

    localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

    always_ff @(posedge clk) begin
        if (rst || clr) idx <= '0;
        else if (adv)   idx <= idx + 1'b1;
    end

    assign last = (idx == LAST_IDX);

endmodule

// File: rtl/ctx_frame_buf.sv
module ctx_frame_buf #(
    parameter int N  = 16,
    parameter int W  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [N-1:0][W-1:0] load_words,
    input  logic                wr,
    input  logic [IW-1:0]       wr_idx,
    input  logic [W-1:0]        wr_data,
    output logic [N-1:0][W-1:0] words
);

    for (genvar k = 0; k < N; k++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)                           words[k] <= '0;
            else if (load)                     words[k] <= load_words[k];
            else if (wr && wr_idx == IW'(k))   words[k] <= wr_data;
        end
    end

endmodule

// File: rtl/ctx_switch_engine.sv
module ctx_switch_engine
    import ctx_pkg::*;
#(
    parameter int FRAME_WORDS = 16,
    parameter int DEPTH_W     = 7
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                start_call,
    input  logic                                start_ret,
    input  logic [WORD_W-1:0]                   link_in,
    input  logic [WORD_W-1:0]                   stat_in,
    input  logic [WORD_W-1:0]                   free_in,
    input  logic [WORD_W-1:0]                   limit_in,
    input  logic [7:0]                          prio_in,
    input  logic                                int_en_in,
    input  logic [WORD_W-1:0]                   call_ra_in,
    input  logic [(FRAME_WORDS-2)*WORD_W-1:0]   regs_in,
    output logic                                mem_req,
    output logic                                mem_we,
    output logic [WORD_W-1:0]                   mem_addr,
    output logic [WORD_W-1:0]                   mem_wdata,
    input  logic [WORD_W-1:0]                   mem_rdata,
    input  logic                                mem_ready,
    output logic                                busy,
    output logic                                done,
    output logic [WORD_W-1:0]                   link_out,
    output logic [WORD_W-1:0]                   stat_out,
    output logic [WORD_W-1:0]                   free_out,
    output logic [(FRAME_WORDS-2)*WORD_W-1:0]   regs_out,
    output logic [WORD_W-1:0]                   ret_pc,
    output logic                                trap_free_empty,
    output logic                                trap_free_last,
    output logic                                trap_depth_over,
    output logic                                trap_depth_under,
    output logic                                trap_no_ctx,
    output logic                                trap_ctx_kind
);

    localparam int REG_WORDS = FRAME_WORDS - 2;
    localparam int IDX_W     = $clog2(FRAME_WORDS);
    localparam int XFER_W    = $clog2(FRAME_WORDS + 2);
    localparam logic [XFER_W-1:0] XFER_TOTAL = XFER_W'(FRAME_WORDS + 1);

    phase_e              phase;
    op_e                 op;
    trap_t               traps;
    logic [WORD_W-1:0]   cap_link, cap_stat, cap_free, cap_limit, cap_ra;
    logic [7:0]          cap_prio;
    logic                cap_ie;
    logic [PTR_W-1:0]    next_free;
    logic [WORD_W-1:0]   base;
    logic                ra_swap;
    logic [XFER_W-1:0]   xfer_cnt;

    logic                go;
    logic                xfer;
    logic [IDX_W-1:0]    idx;
    logic                idx_last;
    logic [FRAME_WORDS-1:0][WORD_W-1:0] words;

    logic                counting, inc_wraps, count_zero;
    logic [DEPTH_W-1:0]  field_inc;

    logic                call_fcu, call_cdo, ret_csu, ret_ctyp, ret_cdu;

    assign go   = (phase == S_IDLE) && (start_call || start_ret);
    assign xfer = mem_req && mem_ready;

    ctx_depth_unit #(.DEPTH_W(DEPTH_W)) u_depth (
        .field      (cap_stat[DEPTH_W-1:0]),
        .enable     (cap_stat[DEPTH_W]),
        .counting   (counting),
        .field_inc  (field_inc),
        .inc_wraps  (inc_wraps),
        .count_zero (count_zero)
    );

    ctx_step_ctr #(.N(FRAME_WORDS), .IW(IDX_W)) u_step (
        .clk  (clk),
        .rst  (rst),
        .clr  (phase == S_CHECK),
        .adv  (xfer && (phase == S_WR_FRAME || phase == S_RD_FRAME)),
        .idx  (idx),
        .last (idx_last)
    );

    ctx_frame_buf #(.N(FRAME_WORDS), .W(WORD_W), .IW(IDX_W)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .load       (go),
        .load_words ({regs_in, stat_in, link_in}),
        .wr         (xfer && phase == S_RD_FRAME),
        .wr_idx     (idx),
        .wr_data    (mem_rdata),
        .words      (words)
    );

    // fault conditions decided from the captured operands
    always_comb begin
        call_fcu = (cap_free[PTR_W-1:0] == '0);
        call_cdo = inc_wraps;
        ret_csu  = (cap_link[PTR_W-1:0] == '0);
        ret_ctyp = !cap_link[LNK_UPPER];
        ret_cdu  = counting && count_zero;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= S_IDLE;
            op        <= OP_CALL;
            traps     <= '0;
            cap_link  <= '0;
            cap_stat  <= '0;
            cap_free  <= '0;
            cap_limit <= '0;
            cap_ra    <= '0;
            cap_prio  <= '0;
            cap_ie    <= 1'b0;
            next_free <= '0;
            base      <= '0;
            ra_swap   <= 1'b0;
            link_out  <= '0;
            stat_out  <= '0;
            free_out  <= '0;
            ret_pc    <= '0;
        end else begin
            unique case (phase)
                S_IDLE: if (go) begin
                    op        <= start_call ? OP_CALL : OP_RET;
                    traps     <= '0;
                    ra_swap   <= 1'b0;
                    cap_link  <= link_in;
                    cap_stat  <= stat_in;
                    cap_free  <= free_in;
                    cap_limit <= limit_in;
                    cap_ra    <= call_ra_in;
                    cap_prio  <= prio_in;
                    cap_ie    <= int_en_in;
                    ret_pc    <= {regs_in[2*WORD_W-1:WORD_W+1], 1'b0};
                    phase     <= S_CHECK;
                end
                S_CHECK: begin
                    if (op == OP_CALL) begin
                        base             <= frame_base(cap_free[PTR_W-1:0]);
                        traps.free_empty <= call_fcu;
                        traps.depth_over <= call_cdo;
                        traps.free_last  <= !(call_fcu || call_cdo) && (cap_free == cap_limit);
                        phase            <= (call_fcu || call_cdo) ? S_FINISH : S_RD_LINK;
                    end else begin
                        base              <= frame_base(cap_link[PTR_W-1:0]);
                        traps.no_ctx      <= ret_csu;
                        traps.ctx_kind    <= ret_ctyp;
                        traps.depth_under <= ret_cdu;
                        phase             <= (ret_csu || ret_ctyp || ret_cdu) ? S_FINISH : S_RD_FRAME;
                    end
                    // aborted operations report the incoming values
                    link_out <= cap_link;
                    stat_out <= cap_stat;
                    free_out <= cap_free;
                end
                S_RD_LINK: if (mem_ready) begin
                    next_free <= mem_rdata[PTR_W-1:0];
                    phase     <= S_WR_FRAME;
                end
                S_WR_FRAME: if (mem_ready && idx_last) begin
                    link_out <= {cap_prio, cap_ie, 1'b1, cap_link[21:20], cap_free[PTR_W-1:0]};
                    stat_out <= {cap_stat[WORD_W-1:DEPTH_W+1], 1'b1,
                                 counting ? field_inc : cap_stat[DEPTH_W-1:0]};
                    free_out <= {cap_free[WORD_W-1:PTR_W], next_free};
                    ra_swap  <= 1'b1;
                    phase    <= S_FINISH;
                end
                S_RD_FRAME: if (mem_ready && idx_last) phase <= S_WR_BACK;
                S_WR_BACK: if (mem_ready) begin
                    link_out <= words[0];
                    stat_out <= words[1];
                    free_out <= {cap_free[WORD_W-1:PTR_W], cap_link[PTR_W-1:0]};
                    phase    <= S_FINISH;
                end
                S_FINISH: phase <= S_IDLE;
                default:  phase <= S_IDLE;
            endcase
        end
    end

    // memory port
    always_comb begin
        mem_req   = (phase == S_RD_LINK) || (phase == S_WR_FRAME) ||
                    (phase == S_RD_FRAME) || (phase == S_WR_BACK);
        mem_we    = (phase == S_WR_FRAME) || (phase == S_WR_BACK);
        mem_addr  = base;
        mem_wdata = '0;
        if (phase == S_WR_FRAME || phase == S_RD_FRAME)
            mem_addr = base + {{(WORD_W-IDX_W-2){1'b0}}, idx, 2'b00};
        if (phase == S_WR_FRAME) mem_wdata = words[idx];
        if (phase == S_WR_BACK)  mem_wdata = cap_free;
    end

    assign busy = (phase != S_IDLE) && (phase != S_FINISH);
    assign done = (phase == S_FINISH);

    for (genvar k = 0; k < REG_WORDS; k++) begin : g_regs
        if (k == 1) begin : g_ra
            assign regs_out[k*WORD_W +: WORD_W] = ra_swap ? cap_ra : words[k+2];
        end else begin : g_pass
            assign regs_out[k*WORD_W +: WORD_W] = words[k+2];
        end
    end

    assign trap_free_empty  = traps.free_empty;
    assign trap_free_last   = traps.free_last;
    assign trap_depth_over  = traps.depth_over;
    assign trap_depth_under = traps.depth_under;
    assign trap_no_ctx      = traps.no_ctx;
    assign trap_ctx_kind    = traps.ctx_kind;

    // accepted transfers since the start, for the checks below
    always_ff @(posedge clk) begin
        if (rst || go) xfer_cnt <= '0;
        else if (xfer) xfer_cnt <= xfer_cnt + 1'b1;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R12
    AST_ADDR_SHAPE: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[27:22] == '0) && (mem_addr[1:0] == 2'b00)); // R1
    AST_ABORT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        done && (trap_free_empty || trap_depth_over || trap_no_ctx || trap_ctx_kind || trap_depth_under)
        |-> xfer_cnt == '0); // R4
    AST_CALL_XFERS: assert property (@(posedge clk) disable iff (rst)
        done && op == OP_CALL && !trap_free_empty && !trap_depth_over |-> xfer_cnt == XFER_TOTAL); // R2
    AST_RET_XFERS: assert property (@(posedge clk) disable iff (rst)
        done && op == OP_RET && !trap_no_ctx && !trap_ctx_kind && !trap_depth_under
        |-> xfer_cnt == XFER_TOTAL); // R7
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && !mem_req); // R12

endmodule

// File: tb/ctx_switch_engine_test.sv
`timescale 1ns/1ps
module ctx_switch_engine_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_call = 1'b0, start_ret = 1'b0;
    logic [31:0]  link_in = '0, stat_in = '0, free_in = '0, limit_in = '0, call_ra_in = '0;
    logic [7:0]   prio_in = '0;
    logic         int_en_in = 1'b0;
    logic [447:0] regs_in = '0;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr, mem_wdata;
    logic [31:0]  mem_rdata = '0;
    logic         mem_ready = 1'b0;
    logic         busy, done;
    logic [31:0]  link_out, stat_out, free_out, ret_pc;
    logic [447:0] regs_out;
    logic         trap_free_empty, trap_free_last, trap_depth_over;
    logic         trap_depth_under, trap_no_ctx, trap_ctx_kind;

    always #2 clk = ~clk;   // 250 MHz

    ctx_switch_engine uut (.*);

    logic [31:0] mem [logic [31:0]];
    logic        q_we[$];
    logic [31:0] q_addr[$];
    logic [31:0] q_data[$];
    string       q_tag[$];
    int checks = 0, fails = 0, stall = 0, cycles = 0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] fbase(input logic [31:0] p);
        return {p[19:16], 6'b0, p[15:0], 6'b0};
    endfunction

    // count part of a nesting field, from its leading-ones prefix
    function automatic logic [6:0] cnt7(input logic [6:0] f);
        int w;
        w = 7;
        for (int i = 6; i >= 0; i--) begin
            if (f[i] && w == i + 1) w = i;
        end
        return f & 7'((1 << w) - 1);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic push(input logic we, input logic [31:0] a, input logic [31:0] d, input string tag);
        q_we.push_back(we); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(tag);
    endtask

    // memory model and access monitor
    always @(negedge clk) begin
        logic rdy;
        cycles++;
        rdy = mem_req && ((stall % 3) != 2);
        if (mem_req) stall++;
        mem_ready = rdy;
        mem_rdata = (rdy && !mem_we) ? rd(mem_addr) : 32'h0;
        if (rdy) begin
            checks++;
            if (q_we.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected access got %h exp none", mem_addr);
            end else begin
                logic        ew;
                logic [31:0] ea, ed;
                string       et;
                ew = q_we.pop_front(); ea = q_addr.pop_front();
                ed = q_data.pop_front(); et = q_tag.pop_front();
                if (mem_we !== ew || mem_addr !== ea || (ew && mem_wdata !== ed)) begin
                    fails++;
                    $display("FAIL %s access got we=%b a=%h d=%h exp we=%b a=%h d=%h",
                             et, mem_we, mem_addr, mem_wdata, ew, ea, ed);
                end
            end
            if (mem_we) mem[mem_addr] = mem_wdata;
        end
        if (cycles > 190000) begin
            fails++;
            $display("FAIL watchdog got hang exp finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic pulse(input bit call, input bit poke);
        @(negedge clk); start_call = call; start_ret = !call;
        @(negedge clk); start_call = 1'b0; start_ret = 1'b0;
        chk("R12 busy after start", {31'b0, busy}, 32'd1);
        if (poke) begin
            @(negedge clk); start_ret = 1'b1;
            @(negedge clk); start_ret = 1'b0;
        end
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (done !== 1'b1 && n < 3000) begin @(negedge clk); n++; end
        if (done !== 1'b1) begin
            fails++;
            $display("FAIL R12 done got 0 exp 1");
        end
    endtask

    task automatic do_call(input bit poke);
        logic [31:0] b, lw, ex_stat;
        logic [6:0]  nf;
        logic        fcu, en, ovf, ab;
        b   = fbase(free_in);
        fcu = (free_in[19:0] == 0);
        en  = stat_in[7] && (stat_in[6:0] != 7'h7F);
        nf  = stat_in[6:0] + 7'd1;
        ovf = en && (cnt7(nf) == 0);
        ab  = fcu || ovf;
        lw  = rd(b);
        ex_stat = {stat_in[31:8], 1'b1, en ? nf : stat_in[6:0]};
        if (!ab) begin
            push(1'b0, b, 32'h0, "R2");
            push(1'b1, b, link_in, "R2");
            push(1'b1, b + 4, stat_in, "R2");
            for (int k = 0; k < 14; k++) push(1'b1, b + 8 + 4*k, regs_in[k*32 +: 32], "R2");
        end
        pulse(1'b1, poke);
        wait_done();
        chk("R4 trap_free_empty", {31'b0, trap_free_empty}, {31'b0, fcu});
        chk("R9 trap_depth_over", {31'b0, trap_depth_over}, {31'b0, ovf});
        chk("R5 trap_free_last", {31'b0, trap_free_last}, {31'b0, !ab && (free_in == limit_in)});
        if (ab) begin
            chk("R4 link unchanged", link_out, link_in);
            chk("R9 stat unchanged", stat_out, stat_in);
            chk("R4 free unchanged", free_out, free_in);
        end else begin
            chk("R3 link_out", link_out, {prio_in, int_en_in, 1'b1, link_in[21:20], free_in[19:0]});
            chk("R3 free_out", free_out, {free_in[31:20], lw[19:0]});
            chk("R8 stat_out", stat_out, ex_stat);
            chk("R3 ra word", regs_out[63:32], call_ra_in);
            chk("R3 word0 kept", regs_out[31:0], regs_in[31:0]);
        end
        chk("R2 queue drained", q_we.size(), 0);
    endtask

    task automatic do_ret();
        logic [31:0] b;
        logic [31:0] ex[16];
        logic        csu, ctyp, cdu, ab;
        b    = fbase(link_in);
        csu  = (link_in[19:0] == 0);
        ctyp = !link_in[22];
        cdu  = stat_in[7] && (stat_in[6:0] != 7'h7F) && (cnt7(stat_in[6:0]) == 0);
        ab   = csu || ctyp || cdu;
        for (int k = 0; k < 16; k++) ex[k] = rd(b + 4*k);
        if (!ab) begin
            for (int k = 0; k < 16; k++) push(1'b0, b + 4*k, 32'h0, "R7");
            push(1'b1, b, free_in, "R7");
        end
        pulse(1'b0, 1'b0);
        wait_done();
        chk("R6 trap_no_ctx", {31'b0, trap_no_ctx}, {31'b0, csu});
        chk("R6 trap_ctx_kind", {31'b0, trap_ctx_kind}, {31'b0, ctyp});
        chk("R10 trap_depth_under", {31'b0, trap_depth_under}, {31'b0, cdu});
        if (ab) begin
            chk("R6 free unchanged", free_out, free_in);
        end else begin
            chk("R7 link_out", link_out, ex[0]);
            chk("R7 stat_out", stat_out, ex[1]);
            chk("R7 free_out", free_out, {free_in[31:20], link_in[19:0]});
            for (int k = 0; k < 14; k++) chk("R7 reg word", regs_out[k*32 +: 32], ex[k+2]);
            chk("R11 ret_pc", ret_pc, {regs_in[63:33], 1'b0});
        end
        chk("R7 queue drained", q_we.size(), 0);
    endtask

    task automatic set_regs(input logic [31:0] seed);
        for (int k = 0; k < 14; k++) regs_in[k*32 +: 32] = seed + 32'h0101_0111 * k;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk("R12 reset busy", {31'b0, busy}, 32'd0);
        chk("R12 reset done", {31'b0, done}, 32'd0);
        chk("R12 reset mem_req", {31'b0, mem_req}, 32'd0);

        mem[32'h3000_0400] = 32'h0002_0020;   // frame A links to frame B
        mem[32'h2000_0800] = 32'h0001_0005;   // frame B links onwards

        // call 1: nesting enabled, field 0
        link_in = 32'h1234_0777; stat_in = 32'h0000_0080; free_in = 32'hABC3_0010;
        limit_in = 32'h0001_0005; prio_in = 8'h42; int_en_in = 1'b1; call_ra_in = 32'h8000_1236;
        set_regs(32'h1000_0000);
        do_call(1'b0);

        // call 2 chained, free pointer hits the limit, start_ret poked while busy
        link_in = link_out; stat_in = stat_out; free_in = free_out;
        limit_in = free_out; prio_in = 8'h07; int_en_in = 1'b0; call_ra_in = 32'h8000_2000;
        set_regs(32'h2000_0000);
        do_call(1'b1);
        repeat (3) @(negedge clk);
        chk("R12 poke ignored busy", {31'b0, busy}, 32'd0);
        chk("R12 poke ignored queue", q_we.size(), 0);

        // return 1 restores frame B, return 2 restores frame A
        link_in = link_out; stat_in = stat_out; free_in = free_out;
        set_regs(32'h9000_0011);
        do_ret();
        link_in = link_out; stat_in = stat_out; free_in = free_out;
        set_regs(32'h5555_0003);
        do_ret();
        chk("R7 original link back", link_out, 32'h1234_0777);

        // call with empty free list
        link_in = 32'h0040_0001; stat_in = 32'h0000_0080; free_in = 32'hFFF0_0000;
        do_call(1'b0);
        // nesting overflow: field 0x3F
        free_in = 32'h0000_0001; stat_in = 32'h0000_00BF;
        do_call(1'b0);
        // nesting field with one leading one, count 0x1E
        stat_in = 32'h0000_00DE; limit_in = 32'h0;
        do_call(1'b0);
        // counting off: all-ones field, then enable bit clear
        free_in = 32'h0000_0002; stat_in = 32'h0000_00FF;
        do_call(1'b0);
        free_in = 32'h0000_0003; stat_in = 32'h0000_0005;
        do_call(1'b0);
        // one-bit count at its top: 0x7E wraps
        free_in = 32'h0000_0004; stat_in = 32'h0000_00FE;
        do_call(1'b0);

        // return faults
        free_in = 32'h0000_0009; stat_in = 32'h0;
        link_in = 32'h0040_0000; do_ret();   // null link
        link_in = 32'h0000_0040; do_ret();   // upper flag clear
        link_in = 32'h0040_0040; stat_in = 32'h0000_00C0; do_ret();   // zero count

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule